// File: doc/BRIEF.md
# Sample-Rate Synthesizer Factor Search

This block chooses the integer settings of a sample-clock synthesizer so that the produced sample rate comes as close as possible to a requested one. The synthesizer divides a 12.8 MHz reference by a pre-divider, multiplies it by a feedback multiplier, then divides the result by a post-divider and by an oversampling factor. The requested rate is given in millihertz. A one-cycle start pulse begins a search. The search visits every pre-divider and post-divider pair. For each pair it works out the feedback multiplier that fits best, and it keeps the combination with the smallest error.

One rate serves every channel of the acquisition system, so there is one request and one result per search. A single serial divider handles all the arithmetic. For each pair it performs one division to find the multiplier and a second division to find the exact rate that multiplier gives. When the search ends, the block raises done for one cycle. At that point the outputs hold the chosen factors, the oversampling factor and the exact rate, or they hold zeros with valid low if no combination satisfies all limits.

Top module: `pll_factor_search`

## Requirements
- R1: After reset, busy, done and valid are 0 and pre_div, fb_mult, post_div, ovs and rate_milli are all 0.
- R2: A start pulse is accepted only while busy is 0, and this includes the cycle in which done is high. A start pulse seen while busy is 1 has no effect on the search in progress or on its result.
- R3: ovs is 1024 when the accepted target is at most 51,200,000 mHz and 256 when it is above that value.
- R4: When valid is 1, pre_div lies in 2..51, fb_mult lies in 8..1600 and post_div lies in 1..127.
- R5: When valid is 1, 12,800 kHz × fb_mult / pre_div lies inside 100..400 MHz, both ends included.
- R6: When valid is 1, rate_milli equals floor(12.8e9 × fb_mult / (pre_div × post_div × ovs)) in mHz.
- R7: For each pair, the multiplier is round(target × pre_div × post_div × ovs / 12.8e9), with halves rounded up, then clamped into 8..1600. The reported combination has the smallest |rate − target| among all pairs whose clamped multiplier passes R5.
- R8: When two pairs give the same error, the one found first is kept. Pairs are visited with pre_div ascending in the outer loop and post_div ascending in the inner loop.
- R9: If no pair passes R5, done is raised with valid 0 and all of pre_div, fb_mult, post_div, ovs and rate_milli are 0.
- R10: done is high for exactly one cycle per accepted start. The result outputs and valid change only in the cycle in which done is high.
- R11: busy rises in the cycle after an accepted start and stays high until the cycle in which done is high, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search |
| target_milli | input | TGT_W | Requested sample rate in mHz, sampled with start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| valid | output | 1 | The last search found a legal combination |
| pre_div | output | Q_W | Chosen pre-divider |
| fb_mult | output | P_W | Chosen feedback multiplier |
| post_div | output | N_W | Chosen post-divider |
| ovs | output | OVS_W | Chosen oversampling factor |
| rate_milli | output | RATE_W | Exact achieved rate in mHz |

## Verification
Two events can fall in the same cycle: the end of one search, marked by the done pulse and the loading of the results, and the acceptance of the next start. The bench provokes this by driving start in the very cycle done is seen high. It then expects busy to rise on the next edge, the fresh results to stay fixed through the whole second search, and the second done to carry the second target's answer. A start driven in the middle of a search is also applied, and the bench expects the reported result to belong to the first target.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_P_LAUNCH,
    ST_P_WAIT,
    ST_P_CHECK,
    ST_R_LAUNCH,
    ST_R_WAIT,
    ST_SCORE,
    ST_STEP,
    ST_FINISH
  } srch_state_e;

endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int W = 64,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [W:0]       trial;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    trial  = {rem_q, quo_q[W-1]};
    if (go) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = CNT_W'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = W'(trial - {1'b0, den_q});
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int W           = 64,
  parameter int Q_W         = 6,
  parameter int P_W         = 11,
  parameter int P_MIN       = 8,
  parameter int P_MAX       = 1600,
  parameter int REF_KHZ     = 12800,
  parameter int VCO_MIN_MHZ = 100,
  parameter int VCO_MAX_MHZ = 400
) (
  input  logic [W-1:0]   p_raw,
  input  logic [Q_W-1:0] q,
  output logic [P_W-1:0] p_fit,
  output logic           vco_ok
);

  logic [W-1:0] vco_khz;
  logic [W-1:0] lo_khz;
  logic [W-1:0] hi_khz;

  always_comb begin
    if (p_raw < W'(P_MIN)) begin
      p_fit = P_W'(P_MIN);
    end else if (p_raw > W'(P_MAX)) begin
      p_fit = P_W'(P_MAX);
    end else begin
      p_fit = p_raw[P_W-1:0];
    end
  end

  always_comb begin
    vco_khz = W'(REF_KHZ) * W'(p_fit);
    lo_khz  = W'(VCO_MIN_MHZ) * W'(1000) * W'(q);
    hi_khz  = W'(VCO_MAX_MHZ) * W'(1000) * W'(q);
    vco_ok  = (vco_khz >= lo_khz) && (vco_khz <= hi_khz);
  end

endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep #(
  parameter int ERR_W  = 64,
  parameter int Q_W    = 6,
  parameter int P_W    = 11,
  parameter int N_W    = 7,
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              offer,
  input  logic [ERR_W-1:0]  err,
  input  logic [Q_W-1:0]    q,
  input  logic [P_W-1:0]    p,
  input  logic [N_W-1:0]    n,
  input  logic [RATE_W-1:0] rate,
  output logic              have,
  output logic [Q_W-1:0]    best_q,
  output logic [P_W-1:0]    best_p,
  output logic [N_W-1:0]    best_n,
  output logic [RATE_W-1:0] best_rate
);

  logic              have_q, have_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic [Q_W-1:0]    q_q, q_d;
  logic [P_W-1:0]    p_q, p_d;
  logic [N_W-1:0]    n_q, n_d;
  logic [RATE_W-1:0] r_q, r_d;
  logic              take;

  // strictly smaller error wins, so the earliest of equals stays
  assign take = offer && (!have_q || (err < err_q));

  always_comb begin
    have_d = have_q;
    err_d  = err_q;
    q_d    = q_q;
    p_d    = p_q;
    n_d    = n_q;
    r_d    = r_q;
    if (clear) begin
      have_d = 1'b0;
    end else if (take) begin
      have_d = 1'b1;
      err_d  = err;
      q_d    = q;
      p_d    = p;
      n_d    = n;
      r_d    = rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      err_q  <= '0;
      q_q    <= '0;
      p_q    <= '0;
      n_q    <= '0;
      r_q    <= '0;
    end else begin
      have_q <= have_d;
      err_q  <= err_d;
      q_q    <= q_d;
      p_q    <= p_d;
      n_q    <= n_d;
      r_q    <= r_d;
    end
  end

  assign have      = have_q;
  assign best_q    = q_q;
  assign best_p    = p_q;
  assign best_n    = n_q;
  assign best_rate = r_q;

endmodule

// File: rtl/pll_factor_search.sv
module pll_factor_search
  import pll_search_pkg::*;
#(
  parameter int TGT_W       = 32,
  parameter int RATE_W      = 32,
  parameter int DIV_W       = 64,
  parameter int Q_MIN       = 2,
  parameter int Q_MAX       = 51,
  parameter int N_MIN       = 1,
  parameter int N_MAX       = 127,
  parameter int P_MIN       = 8,
  parameter int P_MAX       = 1600,
  parameter int OVS_SLOW    = 1024,
  parameter int OVS_FAST    = 256,
  parameter longint unsigned OVS_SPLIT_MILLI = 64'd51_200_000,
  parameter int REF_KHZ     = 12800,
  parameter int VCO_MIN_MHZ = 100,
  parameter int VCO_MAX_MHZ = 400,
  localparam int Q_W   = $clog2(Q_MAX + 1),
  localparam int N_W   = $clog2(N_MAX + 1),
  localparam int P_W   = $clog2(P_MAX + 1),
  localparam int OVS_W = $clog2(OVS_SLOW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TGT_W-1:0]  target_milli,
  output logic              busy,
  output logic              done,
  output logic              valid,
  output logic [Q_W-1:0]    pre_div,
  output logic [P_W-1:0]    fb_mult,
  output logic [N_W-1:0]    post_div,
  output logic [OVS_W-1:0]  ovs,
  output logic [RATE_W-1:0] rate_milli
);

  localparam logic [DIV_W-1:0] REF_MILLI  = DIV_W'(REF_KHZ) * DIV_W'(1_000_000);
  localparam logic [DIV_W-1:0] HALF_MILLI = REF_MILLI >> 1;

  srch_state_e       st_q, st_d;
  logic [TGT_W-1:0]  tgt_q, tgt_d;
  logic [OVS_W-1:0]  ovs_q, ovs_d;
  logic [Q_W-1:0]    qi_q, qi_d;
  logic [N_W-1:0]    ni_q, ni_d;
  logic [P_W-1:0]    pc_q, pc_d;
  logic [RATE_W-1:0] rc_q, rc_d;

  logic              done_q, done_d;
  logic              vld_q, vld_d;
  logic [Q_W-1:0]    oq_q, oq_d;
  logic [P_W-1:0]    op_q, op_d;
  logic [N_W-1:0]    on_q, on_d;
  logic [OVS_W-1:0]  oo_q, oo_d;
  logic [RATE_W-1:0] or_q, or_d;

  logic              start_ok;
  logic              div_go, div_done;
  logic [DIV_W-1:0]  div_num, div_den, div_quo;
  logic [DIV_W-1:0]  pair_den;
  logic [P_W-1:0]    p_fit;
  logic              vco_ok;
  logic              rate_fits;
  logic [DIV_W-1:0]  err_abs;
  logic              offer;
  logic              best_have;
  logic [Q_W-1:0]    best_q;
  logic [P_W-1:0]    best_p;
  logic [N_W-1:0]    best_n;
  logic [RATE_W-1:0] best_rate;

  assign start_ok = (st_q == ST_IDLE) && start;
  assign pair_den = DIV_W'(qi_q) * DIV_W'(ni_q) * DIV_W'(ovs_q);
  assign div_go   = (st_q == ST_P_LAUNCH) || (st_q == ST_R_LAUNCH);

  // one shared divider: multiplier search first, exact rate second
  always_comb begin
    if (st_q == ST_R_LAUNCH) begin
      div_num = REF_MILLI * DIV_W'(pc_q);
      div_den = pair_den;
    end else begin
      div_num = DIV_W'(tgt_q) * DIV_W'(qi_q) * DIV_W'(ni_q) * DIV_W'(ovs_q) + HALF_MILLI;
      div_den = REF_MILLI;
    end
  end

  assign rate_fits = (div_quo >> RATE_W) == '0;
  assign err_abs   = (DIV_W'(rc_q) > DIV_W'(tgt_q)) ? DIV_W'(rc_q) - DIV_W'(tgt_q)
                                                    : DIV_W'(tgt_q) - DIV_W'(rc_q);

  pll_div_seq #(
    .W (DIV_W)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .done (div_done),
    .quo  (div_quo)
  );

  pll_cand_eval #(
    .W          (DIV_W),
    .Q_W        (Q_W),
    .P_W        (P_W),
    .P_MIN      (P_MIN),
    .P_MAX      (P_MAX),
    .REF_KHZ    (REF_KHZ),
    .VCO_MIN_MHZ(VCO_MIN_MHZ),
    .VCO_MAX_MHZ(VCO_MAX_MHZ)
  ) u_eval (
    .p_raw (div_quo),
    .q     (qi_q),
    .p_fit (p_fit),
    .vco_ok(vco_ok)
  );

  pll_best_keep #(
    .ERR_W (DIV_W),
    .Q_W   (Q_W),
    .P_W   (P_W),
    .N_W   (N_W),
    .RATE_W(RATE_W)
  ) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .offer    (offer),
    .err      (err_abs),
    .q        (qi_q),
    .p        (pc_q),
    .n        (ni_q),
    .rate     (rc_q),
    .have     (best_have),
    .best_q   (best_q),
    .best_p   (best_p),
    .best_n   (best_n),
    .best_rate(best_rate)
  );

  always_comb begin
    st_d   = st_q;
    tgt_d  = tgt_q;
    ovs_d  = ovs_q;
    qi_d   = qi_q;
    ni_d   = ni_q;
    pc_d   = pc_q;
    rc_d   = rc_q;
    done_d = 1'b0;
    vld_d  = vld_q;
    oq_d   = oq_q;
    op_d   = op_q;
    on_d   = on_q;
    oo_d   = oo_q;
    or_d   = or_q;
    offer  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          tgt_d = target_milli;
          ovs_d = (64'(target_milli) <= OVS_SPLIT_MILLI) ? OVS_W'(OVS_SLOW) : OVS_W'(OVS_FAST);
          qi_d  = Q_W'(Q_MIN);
          ni_d  = N_W'(N_MIN);
          st_d  = ST_P_LAUNCH;
        end
      end
      ST_P_LAUNCH: st_d = ST_P_WAIT;
      ST_P_WAIT: begin
        if (div_done) st_d = ST_P_CHECK;
      end
      ST_P_CHECK: begin
        if (vco_ok) begin
          pc_d = p_fit;
          st_d = ST_R_LAUNCH;
        end else begin
          st_d = ST_STEP;
        end
      end
      ST_R_LAUNCH: st_d = ST_R_WAIT;
      ST_R_WAIT: begin
        if (div_done) begin
          if (rate_fits) begin
            rc_d = div_quo[RATE_W-1:0];
            st_d = ST_SCORE;
          end else begin
            st_d = ST_STEP;
          end
        end
      end
      ST_SCORE: begin
        offer = 1'b1;
        st_d  = ST_STEP;
      end
      ST_STEP: begin
        if (ni_q == N_W'(N_MAX)) begin
          if (qi_q == Q_W'(Q_MAX)) begin
            st_d = ST_FINISH;
          end else begin
            qi_d = qi_q + Q_W'(1);
            ni_d = N_W'(N_MIN);
            st_d = ST_P_LAUNCH;
          end
        end else begin
          ni_d = ni_q + N_W'(1);
          st_d = ST_P_LAUNCH;
        end
      end
      ST_FINISH: begin
        done_d = 1'b1;
        vld_d  = best_have;
        oq_d   = best_have ? best_q    : '0;
        op_d   = best_have ? best_p    : '0;
        on_d   = best_have ? best_n    : '0;
        oo_d   = best_have ? ovs_q     : '0;
        or_d   = best_have ? best_rate : '0;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= '0;
      ovs_q  <= '0;
      qi_q   <= '0;
      ni_q   <= '0;
      pc_q   <= '0;
      rc_q   <= '0;
      done_q <= 1'b0;
      vld_q  <= 1'b0;
      oq_q   <= '0;
      op_q   <= '0;
      on_q   <= '0;
      oo_q   <= '0;
      or_q   <= '0;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      ovs_q  <= ovs_d;
      qi_q   <= qi_d;
      ni_q   <= ni_d;
      pc_q   <= pc_d;
      rc_q   <= rc_d;
      done_q <= done_d;
      vld_q  <= vld_d;
      oq_q   <= oq_d;
      op_q   <= op_d;
      on_q   <= on_d;
      oo_q   <= oo_d;
      or_q   <= or_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign valid      = vld_q;
  assign pre_div    = oq_q;
  assign fb_mult    = op_q;
  assign post_div   = on_q;
  assign ovs        = oo_q;
  assign rate_milli = or_q;

endmodule

// File: rtl/pll_factor_search_chk.sv
module pll_factor_search_chk #(
  parameter int RATE_W      = 32,
  parameter int Q_MIN       = 2,
  parameter int Q_MAX       = 51,
  parameter int N_MIN       = 1,
  parameter int N_MAX       = 127,
  parameter int P_MIN       = 8,
  parameter int P_MAX       = 1600,
  parameter int OVS_SLOW    = 1024,
  parameter int OVS_FAST    = 256,
  parameter int REF_KHZ     = 12800,
  parameter int VCO_MIN_MHZ = 100,
  parameter int VCO_MAX_MHZ = 400,
  localparam int Q_W   = $clog2(Q_MAX + 1),
  localparam int N_W   = $clog2(N_MAX + 1),
  localparam int P_W   = $clog2(P_MAX + 1),
  localparam int OVS_W = $clog2(OVS_SLOW + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              valid,
  input logic [Q_W-1:0]    pre_div,
  input logic [P_W-1:0]    fb_mult,
  input logic [N_W-1:0]    post_div,
  input logic [OVS_W-1:0]  ovs,
  input logic [RATE_W-1:0] rate_milli
);

  localparam longint unsigned REF_MILLI = longint'(REF_KHZ) * 64'd1_000_000;

  logic [63:0] vco_khz, lo_khz, hi_khz, den_all, rate_calc;

  always_comb begin
    vco_khz   = 64'(REF_KHZ) * 64'(fb_mult);
    lo_khz    = 64'(VCO_MIN_MHZ) * 64'd1000 * 64'(pre_div);
    hi_khz    = 64'(VCO_MAX_MHZ) * 64'd1000 * 64'(pre_div);
    den_all   = 64'(pre_div) * 64'(post_div) * 64'(ovs);
    rate_calc = (den_all == 64'd0) ? 64'd0 : (REF_MILLI * 64'(fb_mult)) / den_all;
  end

  assert_busy_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_busy_low_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({valid, pre_div, fb_mult, post_div, ovs, rate_milli}));

  assert_ranges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (pre_div >= Q_W'(Q_MIN)) && (pre_div <= Q_W'(Q_MAX)) &&
              (fb_mult >= P_W'(P_MIN)) && (fb_mult <= P_W'(P_MAX)) &&
              (post_div >= N_W'(N_MIN)) && (post_div <= N_W'(N_MAX)));

  assert_vco_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (vco_khz >= lo_khz) && (vco_khz <= hi_khz));

  assert_ovs_choice_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (ovs == OVS_W'(OVS_SLOW)) || (ovs == OVS_W'(OVS_FAST)));

  assert_exact_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid) |-> (64'(rate_milli) == rate_calc));

  assert_no_fit_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !valid) |-> (pre_div == '0) && (fb_mult == '0) && (post_div == '0) &&
                         (ovs == '0) && (rate_milli == '0));

endmodule

bind pll_factor_search pll_factor_search_chk #(
  .RATE_W     (RATE_W),
  .Q_MIN      (Q_MIN),
  .Q_MAX      (Q_MAX),
  .N_MIN      (N_MIN),
  .N_MAX      (N_MAX),
  .P_MIN      (P_MIN),
  .P_MAX      (P_MAX),
  .OVS_SLOW   (OVS_SLOW),
  .OVS_FAST   (OVS_FAST),
  .REF_KHZ    (REF_KHZ),
  .VCO_MIN_MHZ(VCO_MIN_MHZ),
  .VCO_MAX_MHZ(VCO_MAX_MHZ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .valid     (valid),
  .pre_div   (pre_div),
  .fb_mult   (fb_mult),
  .post_div  (post_div),
  .ovs       (ovs),
  .rate_milli(rate_milli)
);

// File: tb/test_pll_factor_search.sv
module test_pll_factor_search;

  localparam int TQ_MIN = 2;
  localparam int TQ_MAX = 4;
  localparam int TN_MIN = 1;
  localparam int TN_MAX = 6;
  localparam int Q_W    = $clog2(TQ_MAX + 1);
  localparam int N_W    = $clog2(TN_MAX + 1);
  localparam int P_W    = $clog2(1600 + 1);
  localparam int OVS_W  = $clog2(1024 + 1);
  localparam longint unsigned REFM = 64'd12_800_000_000;

  typedef struct {
    bit              v;
    longint unsigned q;
    longint unsigned p;
    longint unsigned n;
    longint unsigned o;
    longint unsigned r;
  } res_t;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [31:0]       target_milli;
  logic              busy;
  logic              done;
  logic              valid;
  logic [Q_W-1:0]    pre_div;
  logic [P_W-1:0]    fb_mult;
  logic [N_W-1:0]    post_div;
  logic [OVS_W-1:0]  ovs;
  logic [31:0]       rate_milli;

  int   n_tests = 0;
  int   n_fails = 0;
  int   cyc     = 0;

  pll_factor_search #(
    .Q_MIN(TQ_MIN),
    .Q_MAX(TQ_MAX),
    .N_MIN(TN_MIN),
    .N_MAX(TN_MAX)
  ) i_pll_factor_search (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .target_milli(target_milli),
    .busy        (busy),
    .done        (done),
    .valid       (valid),
    .pre_div     (pre_div),
    .fb_mult     (fb_mult),
    .post_div    (post_div),
    .ovs         (ovs),
    .rate_milli  (rate_milli)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference: exhaustive search in plain integer arithmetic
  function automatic res_t model(longint unsigned t);
    res_t            r;
    longint unsigned o, best, num, pr, pc, rate, err;
    r    = '{default: 0};
    best = 0;
    o    = (t <= 64'd51_200_000) ? 64'd1024 : 64'd256;
    for (int q = TQ_MIN; q <= TQ_MAX; q++) begin
      for (int n = TN_MIN; n <= TN_MAX; n++) begin
        longint unsigned qq, nn;
        qq  = longint'(q);
        nn  = longint'(n);
        num = t * qq * nn * o + REFM / 2;
        pr  = num / REFM;
        pc  = (pr < 8) ? 8 : ((pr > 1600) ? 1600 : pr);
        if (12800 * pc < 100000 * qq || 12800 * pc > 400000 * qq) continue;
        rate = (REFM * pc) / (qq * nn * o);
        err  = (rate > t) ? rate - t : t - rate;
        if (!r.v || err < best) begin
          r.v = 1; best = err;
          r.q = qq; r.p = pc; r.n = nn; r.o = o; r.r = rate;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    n_tests++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-clock reference tracking and comparison
  res_t            m_exp, m_pend;
  bit              m_busy = 0;
  bit              st_prev = 0;
  longint unsigned tg_prev = 0;
  bit              done_prev = 0;

  initial m_exp = '{default: 0};
  initial m_pend = '{default: 0};

  always @(negedge clk) begin
    if (rst_n) begin
      if (st_prev && !m_busy) begin
        m_busy = 1;
        m_pend = model(tg_prev);
      end
      if (done) begin
        check(m_busy, "R10 done without accepted start", 1, 0);
        check(!done_prev, "R10 done longer than one cycle", 1, 0);
        m_exp  = m_pend;
        m_busy = 0;
      end
      check(busy == m_busy, "R11 busy", longint'(busy), longint'(m_busy));
      check(valid == m_exp.v, "R9 valid", longint'(valid), longint'(m_exp.v));
      check(64'(pre_div) == m_exp.q, "R8 pre_div", 64'(pre_div), m_exp.q);
      check(64'(post_div) == m_exp.n, "R8 post_div", 64'(post_div), m_exp.n);
      check(64'(fb_mult) == m_exp.p, "R7 fb_mult", 64'(fb_mult), m_exp.p);
      check(64'(ovs) == m_exp.o, "R3 ovs", 64'(ovs), m_exp.o);
      check(64'(rate_milli) == m_exp.r, "R6 rate_milli", 64'(rate_milli), m_exp.r);
      done_prev = done;
    end
    st_prev = start;
    tg_prev = 64'(target_milli);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fails++;
      $display("FAIL R11 watchdog expired, search never finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
    end
  end

  task automatic launch_now(input longint unsigned t);
    start        = 1'b1;
    target_milli = t[31:0];
    @(posedge clk); #1;
    start        = 1'b0;
  endtask

  task automatic wait_done;
    while (done !== 1'b1) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic judge(input longint unsigned t, input string tag);
    res_t e;
    e = model(t);
    check(valid == e.v, {tag, " R9 valid"}, longint'(valid), longint'(e.v));
    check(64'(pre_div) == e.q && 64'(post_div) == e.n, {tag, " R8 pair"},
          64'(pre_div) * 1000 + 64'(post_div), e.q * 1000 + e.n);
    check(64'(fb_mult) == e.p, {tag, " R7 multiplier"}, 64'(fb_mult), e.p);
    check(64'(ovs) == e.o, {tag, " R3 oversampling"}, 64'(ovs), e.o);
    check(64'(rate_milli) == e.r, {tag, " R6 rate"}, 64'(rate_milli), e.r);
    if (valid) begin
      check(pre_div >= 2 && pre_div <= 51 && fb_mult >= 8 && fb_mult <= 1600 &&
            post_div >= 1 && post_div <= 127, {tag, " R4 ranges"}, 0, 0);
      check(64'd12800 * 64'(fb_mult) >= 64'd100000 * 64'(pre_div) &&
            64'd12800 * 64'(fb_mult) <= 64'd400000 * 64'(pre_div), {tag, " R5 vco"},
            64'd12800 * 64'(fb_mult) / 64'(pre_div), 0);
    end
  endtask

  task automatic run_one(input longint unsigned t, input string tag);
    launch_now(t);
    wait_done();
    judge(t, tag);
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n        = 1'b0;
    start        = 1'b0;
    target_milli = '0;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check(!busy && !done && !valid, "R1 flags after reset", {busy, done, valid}, 0);
    check(pre_div == 0 && fb_mult == 0 && post_div == 0 && ovs == 0 && rate_milli == 0,
          "R1 results after reset", 64'(rate_milli), 0);

    run_one(64'd50_000_000, "50k ties");
    run_one(64'd51_200_000, "split edge slow");
    run_one(64'd51_200_001, "split edge fast");
    run_one(64'd20_000_000, "20k");
    run_one(64'd100_000_000, "100k");
    run_one(64'd123_456_789, "odd target");
    run_one(64'd1, "tiny target");
    run_one(64'hFFFF_FFFF, "huge target");

    // R2: start during a search is ignored
    launch_now(64'd100_000_000);
    repeat (3) begin @(posedge clk); #1; end
    launch_now(64'd20_000_000);
    wait_done();
    judge(64'd100_000_000, "R2 ignored mid-search start");

    // R2: start in the done cycle begins the next search at once
    launch_now(64'd200_000_000);
    check(busy == 1'b1, "R2 back-to-back busy", longint'(busy), 1);
    wait_done();
    judge(64'd200_000_000, "R2 back-to-back result");
    @(posedge clk); #1;

    run_one(64'd33_333_333, "33.3k");
    repeat (3) begin @(posedge clk); #1; end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

endmodule